// File: doc/BRIEF.md
# Four-Bank Interleaved Word Memory

This block is a 1024-word byte memory spread over four independent synchronous RAM banks. A request names a start address, a word count of one to four and a read or write direction. The block splits it into per-word bank accesses. Words that land in different banks start together, words that share a bank wait their turn, and one response per word comes back in address order.

A mode pin chooses how addresses are spread over the banks. In the low-order spread, neighbouring addresses sit in neighbouring banks, so a short burst usually runs fully in parallel. In the high-order spread, each bank owns one contiguous quarter of the space. A burst there usually stays inside one bank and runs one word per bank cycle. The pin is captured only when a request is accepted, so the mapping stays fixed for the whole of that burst.

Top module: `ibank_mem`

## Requirements
- R1: With `mode_hi` low when a request is accepted, address a uses bank a[1:0] and in-bank location a[9:2].
- R2: With `mode_hi` high when a request is accepted, address a uses bank a[9:8] and in-bank location a[7:0].
- R3: While a burst is in flight, `req_ready` is low and every request input, `mode_hi` included, has no effect on that burst or on memory contents.
- R4: A request is taken in a cycle with `req_valid` and `req_ready` both high. `req_len` holds the word count minus one (0 to 3). Word i has address (req_addr + i) mod 1024, and its write byte is `req_wdata[8i+7:8i]`.
- R5: Words of one burst that map to different banks all start their bank access in the cycle after acceptance.
- R6: A bank starts at most one access every two cycles. Words colliding in one bank start in ascending address order, each two cycles after the previous one.
- R7: A word whose bank access starts in cycle c can be reported from cycle c+3. Responses come one per cycle at most, in address order, and each carries its own address. A read returns the stored byte. A write returns the byte written, with `rsp_write` high.
- R8: `req_ready` rises in the cycle after the last response of a burst.
- R9: After reset, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_hi | input | 1 | 1 = high-order bank select, 0 = low-order interleave |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 10 | Start word address |
| req_len | input | 2 | Word count minus one |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_wdata | input | 32 | Write bytes, word i in bits 8i+7:8i |
| rsp_valid | output | 1 | Response word present |
| rsp_addr | output | 10 | Address of the response word |
| rsp_data | output | 8 | Read byte, or the byte written |
| rsp_write | output | 1 | Response belongs to a write burst |

## Verification
The hardest case to reach from the ports is a burst that mixes parallel and serialised words: two banks each hit twice, or a burst that wraps past address 1023 into a new bank. Only response timing reveals such a schedule. The stimulus gets there with high-order bursts placed across the 255/256 and 511/512 boundaries and at the top of the space, plus a sweep of start addresses and lengths in both modes. A cycle-exact reference predicts every response cycle from the bank each word maps to. Data written under one mapping is read back under the other, so a swapped bank or location field shows up as wrong data. Request inputs and the mode pin are toggled in the middle of bursts to show they are ignored.

// File: rtl/ibank_pkg.sv
package ibank_pkg;
    localparam int NUM_BANKS  = 4;
    localparam int BANK_DEPTH = 256;
    localparam int DATA_W     = 8;
    localparam int MAX_WORDS  = 4;
    localparam int RD_LAT     = 2;

    localparam int SEL_W  = $clog2(NUM_BANKS);
    localparam int OFF_W  = $clog2(BANK_DEPTH);
    localparam int ADDR_W = SEL_W + OFF_W;
    localparam int TAG_W  = $clog2(MAX_WORDS);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef enum logic {MAP_LOW = 1'b0, MAP_HIGH = 1'b1} map_mode_e;

    // One word's access as seen by a bank
    typedef struct packed {
        logic  wr;
        off_t  off;
        data_t wdata;
        tag_t  tag;
    } bank_op_t;

    // Bank result, tagged with the word slot it belongs to
    typedef struct packed {
        tag_t  tag;
        data_t data;
    } bank_rsp_t;

    function automatic sel_t bank_of(addr_t a, map_mode_e m);
        return (m == MAP_HIGH) ? a[ADDR_W-1 -: SEL_W] : a[SEL_W-1:0];
    endfunction

    function automatic off_t offset_of(addr_t a, map_mode_e m);
        return (m == MAP_HIGH) ? a[OFF_W-1:0] : a[ADDR_W-1:SEL_W];
    endfunction
endpackage

// File: rtl/ibank_ram.sv
module ibank_ram
    import ibank_pkg::*;
#(
    parameter int DEPTH = BANK_DEPTH,
    parameter int LAT   = RD_LAT
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      op_vld,
    input  bank_op_t  op,
    output logic      out_vld,
    output bank_rsp_t out
);
    data_t     mem [DEPTH];
    logic [LAT-1:0] pv;
    bank_rsp_t pd [LAT];

    always_ff @(posedge clk) begin
        if (op_vld && op.wr) begin
            mem[op.off] <= op.wdata;
        end
    end

    // valid bits of the read pipeline
    always_ff @(posedge clk) begin
        if (rst) begin
            pv <= '0;
        end else begin
            pv[0] <= op_vld;
            for (int k = 1; k < LAT; k++) begin
                pv[k] <= pv[k-1];
            end
        end
    end

    // payload of the read pipeline; a write echoes its own byte
    always_ff @(posedge clk) begin
        pd[0] <= '{tag: op.tag, data: (op.wr ? op.wdata : mem[op.off])};
        for (int k = 1; k < LAT; k++) begin
            pd[k] <= pd[k-1];
        end
    end

    assign out_vld = pv[LAT-1];
    assign out     = pd[LAT-1];
endmodule

// File: rtl/ibank_sched.sv
module ibank_sched
    import ibank_pkg::*;
#(
    parameter int NB  = NUM_BANKS,
    parameter int NW  = MAX_WORDS,
    parameter int LAT = RD_LAT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  addr_t                ld_addr,
    input  tag_t                 ld_len,
    input  logic                 ld_wr,
    input  logic [NW*DATA_W-1:0] ld_wdata,
    input  map_mode_e            ld_mode,
    output logic [NB-1:0]        bank_vld,
    output bank_op_t             bank_op [NB]
);
    localparam int CW = $clog2(LAT + 1);

    logic [NW-1:0]  pend;
    logic [NW-1:0]  go;
    logic [NB-1:0]  claimed;
    sel_t           wbank [NW];
    bank_op_t       wop   [NW];
    sel_t           nbank [NW];
    bank_op_t       nop   [NW];
    logic [CW-1:0]  hold  [NB];

    // split the burst into words at load time
    always_comb begin
        for (int i = 0; i < NW; i++) begin
            nbank[i] = bank_of(ld_addr + addr_t'(i), ld_mode);
            nop[i]   = '{wr:    ld_wr,
                         off:   offset_of(ld_addr + addr_t'(i), ld_mode),
                         wdata: ld_wdata[i*DATA_W +: DATA_W],
                         tag:   tag_t'(i)};
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            for (int i = 0; i < NW; i++) begin
                wbank[i] <= nbank[i];
                wop[i]   <= nop[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (load) begin
            for (int i = 0; i < NW; i++) begin
                pend[i] <= (tag_t'(i) <= ld_len);
            end
        end else begin
            pend <= pend & ~go;
        end
    end

    // per-bank occupancy counters
    always_ff @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (rst) begin
                hold[b] <= '0;
            end else if (bank_vld[b]) begin
                hold[b] <= CW'(LAT - 1);
            end else if (hold[b] != '0) begin
                hold[b] <= hold[b] - 1'b1;
            end
        end
    end

    // the lowest pending word of each bank starts when its bank is free
    always_comb begin
        claimed  = '0;
        go       = '0;
        bank_vld = '0;
        for (int b = 0; b < NB; b++) begin
            bank_op[b] = '0;
        end
        for (int i = 0; i < NW; i++) begin
            if (pend[i]) begin
                if (!claimed[wbank[i]] && hold[wbank[i]] == '0) begin
                    go[i]              = 1'b1;
                    bank_vld[wbank[i]] = 1'b1;
                    bank_op[wbank[i]]  = wop[i];
                end
                claimed[wbank[i]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ibank_reorder.sv
module ibank_reorder
    import ibank_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int NW = MAX_WORDS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  addr_t         ld_addr,
    input  tag_t          ld_len,
    input  logic          ld_wr,
    input  logic [NB-1:0] in_vld,
    input  bank_rsp_t     in_rsp [NB],
    output logic          active,
    output logic          out_vld,
    output addr_t         out_addr,
    output data_t         out_data,
    output logic          out_wr
);
    logic [NW-1:0] filled;
    data_t         slot [NW];
    tag_t          ptr;
    tag_t          last;
    addr_t         base;
    logic          wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            filled <= '0;
            ptr    <= '0;
            last   <= '0;
            base   <= '0;
            wr_q   <= 1'b0;
        end else if (load) begin
            active <= 1'b1;
            filled <= '0;
            ptr    <= '0;
            last   <= ld_len;
            base   <= ld_addr;
            wr_q   <= ld_wr;
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (in_vld[b]) begin
                    filled[in_rsp[b].tag] <= 1'b1;
                end
            end
            if (out_vld) begin
                ptr <= ptr + 1'b1;
                if (ptr == last) begin
                    active <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (in_vld[b]) begin
                slot[in_rsp[b].tag] <= in_rsp[b].data;
            end
        end
    end

    assign out_vld  = active && filled[ptr];
    assign out_addr = base + addr_t'(ptr);
    assign out_data = slot[ptr];
    assign out_wr   = wr_q;
endmodule

// File: rtl/ibank_mem.sv
module ibank_mem
    import ibank_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        mode_hi,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [TAG_W-1:0]            req_len,
    input  logic                        req_write,
    input  logic [MAX_WORDS*DATA_W-1:0] req_wdata,
    output logic                        rsp_valid,
    output logic [ADDR_W-1:0]           rsp_addr,
    output logic [DATA_W-1:0]           rsp_data,
    output logic                        rsp_write
);
    logic                 accept;
    logic                 active;
    logic [NUM_BANKS-1:0] bank_vld;
    bank_op_t             bank_op [NUM_BANKS];
    logic [NUM_BANKS-1:0] ret_vld;
    bank_rsp_t            ret     [NUM_BANKS];

    assign req_ready = !active;
    assign accept    = req_valid && req_ready;

    ibank_sched u_sched (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .ld_addr  (req_addr),
        .ld_len   (req_len),
        .ld_wr    (req_write),
        .ld_wdata (req_wdata),
        .ld_mode  (map_mode_e'(mode_hi)),
        .bank_vld (bank_vld),
        .bank_op  (bank_op)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        ibank_ram u_ram (
            .clk     (clk),
            .rst     (rst),
            .op_vld  (bank_vld[g]),
            .op      (bank_op[g]),
            .out_vld (ret_vld[g]),
            .out     (ret[g])
        );
    end

    ibank_reorder u_reorder (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .ld_addr  (req_addr),
        .ld_len   (req_len),
        .ld_wr    (req_write),
        .in_vld   (ret_vld),
        .in_rsp   (ret),
        .active   (active),
        .out_vld  (rsp_valid),
        .out_addr (rsp_addr),
        .out_data (rsp_data),
        .out_wr   (rsp_write)
    );
endmodule

// File: rtl/ibank_mem_chk.sv
module ibank_mem_chk
    import ibank_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 rsp_valid,
    input logic [ADDR_W-1:0]    rsp_addr,
    input logic                 rsp_write,
    input logic [NUM_BANKS-1:0] bank_vld
);
    // R8
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    // R4
    accept_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!rsp_valid && !req_ready));

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(rsp_valid)) |-> (rsp_addr == $past(rsp_addr) + ADDR_W'(1)));

    // R3
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(rsp_valid)) |-> (rsp_write == $past(rsp_write)));

    if (RD_LAT > 1) begin : g_gap
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
            // R6
            bank_gap_chk: assert property (@(posedge clk) disable iff (rst)
                bank_vld[b] |=> !bank_vld[b]);
        end
    end
endmodule

bind ibank_mem ibank_mem_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_write (rsp_write),
    .bank_vld  (bank_vld)
);

// File: tb/ibank_mem_tb.sv
module ibank_mem_tb;
    import ibank_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_hi = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [TAG_W-1:0] req_len = '0;
    logic req_write = 1'b0;
    logic [MAX_WORDS*DATA_W-1:0] req_wdata = '0;
    logic rsp_valid;
    logic [ADDR_W-1:0] rsp_addr;
    logic [DATA_W-1:0] rsp_data;
    logic rsp_write;

    int vectors = 0;
    int misses = 0;
    int phys [4][256];

    always #10 clk = ~clk;

    ibank_mem u_dut (
        .clk(clk), .rst(rst), .mode_hi(mode_hi),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_data(rsp_data), .rsp_write(rsp_write)
    );

    task automatic check(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int pat(int a);
        return (a * 37 + (a / 256) * 5 + 11) % 256;
    endfunction

    function automatic logic [31:0] pat4(int a, int salt);
        logic [31:0] w;
        for (int i = 0; i < 4; i++) w[8*i +: 8] = 8'(pat((a + i + salt) % 1024));
        return w;
    endfunction

    // Cycle-exact model: cycle 0 is the accept cycle
    task automatic burst(input int addr, input int len, input bit wr, input bit hi,
                         input bit disturb, input logic [31:0] wd, input string req);
        int bnext[4];
        int emit[4];
        int eaddr[4];
        int edata[4];
        int a, bk, of, iss, rdy, last;
        for (int b = 0; b < 4; b++) bnext[b] = 1;
        for (int i = 0; i <= len; i++) begin
            a = (addr + i) % 1024;
            bk = hi ? a / 256 : a % 4;
            of = hi ? a % 256 : a / 4;
            iss = bnext[bk];
            bnext[bk] = iss + 2;
            rdy = iss + 3;
            if (i == 0) emit[i] = rdy;
            else emit[i] = (rdy > emit[i-1] + 1) ? rdy : emit[i-1] + 1;
            eaddr[i] = a;
            if (wr) begin
                edata[i] = int'(wd[8*i +: 8]);
                phys[bk][of] = edata[i];
            end else begin
                edata[i] = phys[bk][of];
            end
        end
        last = emit[len];

        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = ADDR_W'(addr);
        req_len   = TAG_W'(len);
        req_write = wr;
        req_wdata = wd;
        mode_hi   = hi;
        check(req, "req_ready when offered", int'(req_ready), 1);
        for (int c = 1; c <= last + 1; c++) begin
            int j;
            @(negedge clk);
            if (c == 1) begin
                if (disturb) begin
                    // R3: junk request and flipped mode while busy
                    req_valid = 1'b1;
                    mode_hi   = !hi;
                    req_addr  = ~req_addr;
                    req_len   = ~req_len;
                    req_write = !wr;
                    req_wdata = ~wd;
                end else begin
                    req_valid = 1'b0;
                end
            end
            j = -1;
            for (int k = 0; k <= len; k++) if (emit[k] == c) j = k;
            check(req, "rsp_valid", int'(rsp_valid), int'(j >= 0));
            if (j >= 0) begin
                check(req, "rsp_addr", int'(rsp_addr), eaddr[j]);
                check(req, "rsp_data", int'(rsp_data), edata[j]);
                check(req, "rsp_write", int'(rsp_write), int'(wr));
            end
            check(req, "req_ready (R8)", int'(req_ready), int'(c == last + 1));
            if (c == last) begin
                req_valid = 1'b0;
                mode_hi   = hi;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9", "req_ready after reset", int'(req_ready), 1);
        check("R9", "rsp_valid after reset", int'(rsp_valid), 0);

        // R1 R4: fill the whole space with low-order four-word writes
        for (int base = 0; base < 1024; base += 4)
            burst(base, 3, 1'b1, 1'b0, 1'b0, pat4(base, 0), "R1");

        // R5: four distinct banks in parallel
        burst(0, 3, 1'b0, 1'b0, 1'b0, '0, "R5");
        burst(1022, 3, 1'b0, 1'b0, 1'b0, '0, "R1");
        burst(6, 1, 1'b0, 1'b0, 1'b0, '0, "R4");
        burst(9, 0, 1'b0, 1'b0, 1'b0, '0, "R4");

        // R6 R2: one bank, then bank-boundary crossings in high-order mode
        burst(16, 3, 1'b0, 1'b1, 1'b0, '0, "R6");
        burst(254, 3, 1'b0, 1'b1, 1'b0, '0, "R2");
        burst(511, 2, 1'b0, 1'b1, 1'b0, '0, "R2");
        burst(1023, 1, 1'b0, 1'b1, 1'b0, '0, "R2");

        // R7: write in high-order, read back both ways
        burst(300, 3, 1'b1, 1'b1, 1'b0, 32'hA5C3_1E77, "R7");
        burst(300, 3, 1'b0, 1'b1, 1'b0, '0, "R7");
        burst(176, 3, 1'b0, 1'b0, 1'b0, '0, "R1");

        // R3: request inputs and mode wiggled during bursts
        burst(40, 3, 1'b0, 1'b0, 1'b1, '0, "R3");
        burst(500, 3, 1'b1, 1'b1, 1'b1, 32'h1234_5678, "R3");
        burst(500, 3, 1'b0, 1'b1, 1'b0, '0, "R3");
        burst(125, 3, 1'b0, 1'b0, 1'b0, '0, "R3");

        // R6 R7: mixed sweep
        for (int k = 0; k < 40; k++)
            burst((k * 97 + 250) % 1024, k % 4, (k % 3) == 0, (k % 2) == 1,
                  (k % 5) == 0, pat4(k * 13, 7), "R6");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        vectors++;
        misses++;
        $display("FAIL watchdog run did not complete actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule